// File: doc/BRIEF.md
# Context mailbox command engine

This block is a single 128-bit command word through which software loads or reads back queue context records. Software polls the word until its busy flag is clear. It then writes all 128 bits in one transfer with busy set. The engine takes the command code, the read/write operation, the queue number and the 64-bit address field from that word. It then writes or reads one entry of a small internal context store. When it finishes, it clears busy in the same word and writes a 4-bit status code. A read returns its result in the address field.

The address field is only stored as a 64-bit value and is never dereferenced. Per-queue submission and completion contexts each hold one entry per queue. The event, async-event, submission base table, completion base table and function allocation commands each own a single global entry. The close, flush, stop, source and destination commands act as control commands that only complete. Every operation takes the same fixed number of cycles, `LATENCY`, from the load of the word to the clearing of busy.

Top module: `ctxmb_engine`

## Requirements
- R1: A write to the word with bit 13 (busy) clear loads all 128 bits unchanged. The engine then stays idle and the word holds its value.
- R2: A write with busy set starts an operation. Busy reads 1 for exactly `LATENCY` cycles after the load cycle and then reads 0.
- R3: A write that arrives while busy is set is ignored. The completed word is the one computed from the original command.
- R4: Bit 14 is the operation, 0 for write and 1 for read. A successful write stores the 64-bit value {bits 95:64, bits 63:32} into the entry selected by the command and completes with status (bits 12:9) equal to 0.
- R5: A successful read puts the selected entry into bits 95:32, high half in 95:64, and completes with status 0.
- R6: The command code sits in bits 3:0. Codes 0 (submission context) and 1 (completion context) address separate per-queue entries indexed by the queue number in bits 31:16. Codes 2 to 6 each address one global entry of their own.
- R7: Control codes 7, 8, 9, 10, 12, 13 and 14 complete with status 0. They leave the address field and the store unchanged.
- R8: Codes 11 and 15 complete with status 4'b0001. The address field and the store are left unchanged.
- R9: For codes 0, 1, 8 and 10, a queue number of `NUM_QUEUES` or more completes with status 4'b0010 and no store access. `NUM_QUEUES`-1 is accepted.
- R10: At completion the token (bits 127:96), queue number, command, operation and reserved bits are kept. Any status value written by software is replaced.
- R11: After reset the word reads all zero and every store entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_wr_en | input | 1 | Write strobe for the whole 128-bit word |
| mb_wr_data | input | 128 | Word written by software |
| mb_rd_data | output | 128 | Current word: busy, status and results |

## Verification
A wrong decode of the command or queue number shows at the completion edge, `LATENCY` cycles after the load: the status code or the returned address differs from the value computed for the command. A store entry that was corrupted, aliased or written by a rejected command stays hidden until a later read of that entry. For this reason the sequence reads back every class of entry after writes to its neighbours and after failed commands. A counter that stops early or late shows up at once as a busy window of the wrong length.

// File: rtl/ctxmb_pkg.sv
`timescale 1ns/1ps
package ctxmb_pkg;

    localparam int CMD_W  = 4;
    localparam int STAT_W = 4;
    localparam int QNUM_W = 16;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 2 * ADDR_W;
    localparam int NUM_GLOB = 5;

    localparam logic [STAT_W-1:0] ST_OK      = 4'b0000;
    localparam logic [STAT_W-1:0] ST_BAD_CMD = 4'b0001;
    localparam logic [STAT_W-1:0] ST_BAD_Q   = 4'b0010;

    localparam logic OP_WRITE = 1'b0;
    localparam logic OP_READ  = 1'b1;

    localparam logic [CMD_W-1:0] CMD_SQ_CTX   = 4'd0;
    localparam logic [CMD_W-1:0] CMD_CQ_CTX   = 4'd1;
    localparam logic [CMD_W-1:0] CMD_EV_CTX   = 4'd2;
    localparam logic [CMD_W-1:0] CMD_FN_ALLOC = 4'd6;
    localparam logic [CMD_W-1:0] CMD_CLOSE_Q  = 4'd8;
    localparam logic [CMD_W-1:0] CMD_FLUSH_Q  = 4'd10;
    localparam logic [CMD_W-1:0] CMD_RSV_A    = 4'd11;
    localparam logic [CMD_W-1:0] CMD_RSV_B    = 4'd15;

    typedef enum logic [1:0] {
        CLS_QCTX = 2'd0,
        CLS_GLOB = 2'd1,
        CLS_CTRL = 2'd2,
        CLS_BAD  = 2'd3
    } cls_e;

    typedef struct packed {
        logic              rsv_hi;
        logic              op;
        logic              busy;
        logic [STAT_W-1:0] status;
        logic [4:0]        rsv_lo;
        logic [CMD_W-1:0]  cmd;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] token;
        logic [ADDR_W-1:0] addr_hi;
        logic [ADDR_W-1:0] addr_lo;
        logic [QNUM_W-1:0] queue;
        ctrl_t             ctrl;
    } mbox_t;

    function automatic cls_e cmd_class(input logic [CMD_W-1:0] cmd);
        if (cmd == CMD_RSV_A || cmd == CMD_RSV_B)
            return CLS_BAD;
        else if (cmd <= CMD_CQ_CTX)
            return CLS_QCTX;
        else if (cmd <= CMD_FN_ALLOC)
            return CLS_GLOB;
        else
            return CLS_CTRL;
    endfunction

    function automatic logic needs_queue(input logic [CMD_W-1:0] cmd);
        return (cmd <= CMD_CQ_CTX) || (cmd == CMD_CLOSE_Q) || (cmd == CMD_FLUSH_Q);
    endfunction

    function automatic int idx_width(input int nq);
        return $clog2(2 * nq + NUM_GLOB);
    endfunction

endpackage

// File: rtl/ctxmb_decode.sv
`timescale 1ns/1ps
module ctxmb_decode
    import ctxmb_pkg::*;
#(
    parameter int NUM_QUEUES = 8
) (
    input  logic [CMD_W-1:0]                      cmd,
    input  logic [QNUM_W-1:0]                     queue,
    output cls_e                                  cls,
    output logic [STAT_W-1:0]                     status,
    output logic [idx_width(NUM_QUEUES)-1:0]      idx
);
    localparam int IDX_W  = idx_width(NUM_QUEUES);
    localparam int QSEL_W = $clog2(NUM_QUEUES);
    localparam logic [QNUM_W-1:0] Q_LIMIT = QNUM_W'(NUM_QUEUES);

    logic q_ok;

    always_comb begin
        cls  = cmd_class(cmd);
        q_ok = queue < Q_LIMIT;
        if (cls == CLS_BAD)
            status = ST_BAD_CMD;
        else if (needs_queue(cmd) && !q_ok)
            status = ST_BAD_Q;
        else
            status = ST_OK;

        if (cls == CLS_GLOB)
            idx = IDX_W'(2 * NUM_QUEUES) + IDX_W'(cmd - CMD_EV_CTX);
        else
            idx = (cmd[0] ? IDX_W'(NUM_QUEUES) : '0) + IDX_W'(queue[QSEL_W-1:0]);
    end

endmodule

// File: rtl/ctxmb_store.sv
`timescale 1ns/1ps
module ctxmb_store
    import ctxmb_pkg::*;
#(
    parameter int ENTRIES = 21,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] entry_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry_q[g] <= '0;
            else if (we && idx == IDX_W'(g))
                entry_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (idx == IDX_W'(i))
                rdata = entry_q[i];
    end

endmodule

// File: rtl/ctxmb_seq.sv
`timescale 1ns/1ps
module ctxmb_seq
    import ctxmb_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  mbox_t             wr_word,
    input  cls_e              cls,
    input  logic [STAT_W-1:0] status,
    input  logic [DATA_W-1:0] rdata,
    output mbox_t             word_q,
    output logic              store_we
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             finish;
    logic             access_ok;

    always_comb begin
        finish    = word_q.ctrl.busy && (cnt_q == '0);
        access_ok = (status == ST_OK) && (cls == CLS_QCTX || cls == CLS_GLOB);
        store_we  = finish && access_ok && (word_q.ctrl.op == OP_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (word_q.ctrl.busy) begin
            if (finish) begin
                word_q.ctrl.busy   <= 1'b0;
                word_q.ctrl.status <= status;
                if (access_ok && word_q.ctrl.op == OP_READ) begin
                    word_q.addr_hi <= rdata[DATA_W-1:ADDR_W];
                    word_q.addr_lo <= rdata[ADDR_W-1:0];
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (wr_en) begin
            word_q <= wr_word;
            cnt_q  <= CNT_LOAD;
        end
    end

endmodule

// File: rtl/ctxmb_engine.sv
`timescale 1ns/1ps
module ctxmb_engine
    import ctxmb_pkg::*;
#(
    parameter int NUM_QUEUES = 8,
    parameter int LATENCY    = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mb_wr_en,
    input  logic [127:0] mb_wr_data,
    output logic [127:0] mb_rd_data
);
    localparam int ENTRIES = 2 * NUM_QUEUES + NUM_GLOB;
    localparam int IDX_W   = idx_width(NUM_QUEUES);

    mbox_t             word;
    cls_e              cls;
    logic [STAT_W-1:0] status;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rdata;
    logic              store_we;

    ctxmb_decode #(.NUM_QUEUES(NUM_QUEUES)) u_decode (
        .cmd    (word.ctrl.cmd),
        .queue  (word.queue),
        .cls    (cls),
        .status (status),
        .idx    (idx)
    );

    ctxmb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .idx   (idx),
        .wdata ({word.addr_hi, word.addr_lo}),
        .rdata (rdata)
    );

    ctxmb_seq #(.LATENCY(LATENCY)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (mb_wr_en),
        .wr_word  (mbox_t'(mb_wr_data)),
        .cls      (cls),
        .status   (status),
        .rdata    (rdata),
        .word_q   (word),
        .store_we (store_we)
    );

    assign mb_rd_data = word;

endmodule

// File: rtl/ctxmb_checker.sv
`timescale 1ns/1ps
module ctxmb_checker #(
    parameter int NUM_QUEUES = 8,
    parameter int LATENCY    = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         mb_wr_en,
    input logic [127:0] mb_wr_data,
    input logic [127:0] mb_rd_data
);
    logic       busy;
    logic [3:0] cmd;
    logic [3:0] status;
    logic       q_bad;
    logic       ctrl_cmd;
    int         busy_len;

    assign busy     = mb_rd_data[13];
    assign cmd      = mb_rd_data[3:0];
    assign status   = mb_rd_data[12:9];
    assign q_bad    = mb_rd_data[31:16] >= 16'(NUM_QUEUES);
    assign ctrl_cmd = (cmd == 4'd7) || (cmd == 4'd9) || (cmd == 4'd12) ||
                      (cmd == 4'd13) || (cmd == 4'd14);

    always_ff @(posedge clk) begin
        if (rst)
            busy_len <= 0;
        else if (busy)
            busy_len <= busy_len + 1;
        else
            busy_len <= 0;
    end

    assert_busy_window_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_len == LATENCY);

    assert_idle_load_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && mb_wr_en) |=> mb_rd_data == $past(mb_wr_data));

    assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && mb_wr_en) |=> $stable(mb_rd_data[127:96]) && $stable(mb_rd_data[31:0] & 32'hffff_c1ff));

    assert_keep_ids_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $stable(mb_rd_data[127:96]) && $stable(mb_rd_data[31:16]) &&
                        $stable(mb_rd_data[8:0]) && $stable(mb_rd_data[15:14]));

    assert_bad_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && (cmd == 4'd11 || cmd == 4'd15)) |->
            status == 4'b0001 && $stable(mb_rd_data[95:32]));

    assert_bad_queue_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && q_bad && (cmd <= 4'd1 || cmd == 4'd8 || cmd == 4'd10)) |->
            status == 4'b0010 && $stable(mb_rd_data[95:32]));

    assert_ctrl_ok_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && ctrl_cmd) |-> status == 4'b0000 && $stable(mb_rd_data[95:32]));

endmodule

bind ctxmb_engine ctxmb_checker #(.NUM_QUEUES(NUM_QUEUES), .LATENCY(LATENCY)) u_ctxmb_checker (
    .clk        (clk),
    .rst        (rst),
    .mb_wr_en   (mb_wr_en),
    .mb_wr_data (mb_wr_data),
    .mb_rd_data (mb_rd_data)
);

// File: tb/test_ctxmb_engine.sv
`timescale 1ns/1ps
module test_ctxmb_engine;

    localparam int NQ  = 8;
    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         mb_wr_en;
    logic [127:0] mb_wr_data;
    logic [127:0] mb_rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [127:0] exp_q[$];
    string        tag_q[$];

    logic [63:0] m_q  [2][NQ];
    logic [63:0] m_g  [5];

    always #5 clk = ~clk;

    ctxmb_engine #(.NUM_QUEUES(NQ), .LATENCY(LAT)) i_ctxmb_engine (
        .clk        (clk),
        .rst        (rst),
        .mb_wr_en   (mb_wr_en),
        .mb_wr_data (mb_wr_data),
        .mb_rd_data (mb_rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input logic [3:0] cmd, input logic op, input logic busy,
                                        input logic [3:0] st, input logic [15:0] q,
                                        input logic [63:0] data, input logic [31:0] tok);
        return {tok, data, q, 1'b0, op, busy, st, 5'b0, cmd};
    endfunction

    // Expected completed word, from the requirements; updates the model store.
    function automatic logic [127:0] predict(input logic [127:0] w);
        logic [127:0] e;
        logic [3:0]   c;
        logic [3:0]   st;
        logic [15:0]  q;
        c = w[3:0];
        q = w[31:16];
        e = w;
        if (c == 4'd11 || c == 4'd15)
            st = 4'b0001;
        else if ((c <= 4'd1 || c == 4'd8 || c == 4'd10) && q >= 16'(NQ))
            st = 4'b0010;
        else
            st = 4'b0000;
        e[13]   = 1'b0;
        e[12:9] = st;
        if (st == 4'b0000 && c <= 4'd6) begin
            if (!w[14]) begin
                if (c <= 4'd1) m_q[c[0]][q[2:0]] = w[95:32];
                else           m_g[c - 4'd2]     = w[95:32];
            end else begin
                if (c <= 4'd1) e[95:32] = m_q[c[0]][q[2:0]];
                else           e[95:32] = m_g[c - 4'd2];
            end
        end
        return e;
    endfunction

    task automatic run_cmd(input logic [3:0] cmd, input logic op, input logic [15:0] q,
                           input logic [63:0] data, input logic [31:0] tok,
                           input logic [3:0] st_in, input bit intrude, input string req);
        logic [127:0] w;
        while (mb_rd_data[13]) @(negedge clk);
        w = mk(cmd, op, 1'b1, st_in, q, data, tok);
        exp_q.push_back(predict(w));
        tag_q.push_back(req);
        mb_wr_data = w;
        mb_wr_en   = 1'b1;
        @(negedge clk);
        if (intrude) begin
            mb_wr_data = ~w;
            @(negedge clk);
        end
        mb_wr_en = 1'b0;
    endtask

    // Monitor / scoreboard
    logic prev_busy = 1'b0;
    int   blen      = 0;
    always @(negedge clk) begin
        if (rst) begin
            prev_busy <= 1'b0;
            blen      = 0;
        end else begin
            if (mb_rd_data[13]) begin
                blen = blen + 1;
            end else if (prev_busy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected completion", mb_rd_data, '0);
                end else begin
                    logic [127:0] e;
                    string        t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(mb_rd_data === e, t, mb_rd_data, e);
                    check(blen == LAT, "R2 busy window", 128'(blen), 128'(LAT));
                end
                blen = 0;
            end
            prev_busy <= mb_rd_data[13];
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        check(1'b0, "watchdog expired", '0, '0);
        finish_run();
    end

    initial begin
        logic [127:0] w;
        for (int i = 0; i < NQ; i++) begin
            m_q[0][i] = '0;
            m_q[1][i] = '0;
        end
        for (int i = 0; i < 5; i++) m_g[i] = '0;
        rst        = 1'b1;
        mb_wr_en   = 1'b0;
        mb_wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mb_rd_data === '0, "R11 reset word", mb_rd_data, '0);

        // R11: store empty after reset
        run_cmd(4'd0, 1'b1, 16'd5, 64'hdead_beef_0000_1111, 32'h11, 4'd0, 1'b0, "R11 store zero");

        // R1: load with busy clear, engine stays idle
        while (mb_rd_data[13]) @(negedge clk);
        @(negedge clk);
        w = mk(4'd0, 1'b0, 1'b0, 4'd3, 16'd2, 64'h0123_4567_89ab_cdef, 32'hcafe_0001);
        mb_wr_data = w;
        mb_wr_en   = 1'b1;
        @(negedge clk);
        mb_wr_en = 1'b0;
        check(mb_rd_data === w, "R1 idle load", mb_rd_data, w);
        repeat (LAT + 2) @(negedge clk);
        check(mb_rd_data === w, "R1 idle hold", mb_rd_data, w);

        // R4, R5: write then read submission context
        run_cmd(4'd0, 1'b0, 16'd3, 64'haaaa_0003_5555_0003, 32'h21, 4'd0, 1'b0, "R4 write sq ctx");
        run_cmd(4'd0, 1'b1, 16'd3, 64'h0, 32'h22, 4'd0, 1'b0, "R5 read sq ctx");

        // R6: completion context is separate
        run_cmd(4'd1, 1'b0, 16'd3, 64'hbbbb_1003_6666_1003, 32'h23, 4'd0, 1'b0, "R6 write cq ctx");
        run_cmd(4'd0, 1'b1, 16'd3, 64'h0, 32'h24, 4'd0, 1'b0, "R6 sq unaffected");
        run_cmd(4'd1, 1'b1, 16'd3, 64'h0, 32'h25, 4'd0, 1'b0, "R6 read cq ctx");

        // R6: global entries
        for (int c = 2; c <= 6; c++)
            run_cmd(4'(c), 1'b0, 16'd0, {32'h7000_0000 + 32'(c), 32'h0c0c_0000 + 32'(c)}, 32'h30, 4'd0, 1'b0, "R6 write global");
        for (int c = 2; c <= 6; c++)
            run_cmd(4'(c), 1'b1, 16'd9, 64'h0, 32'h31, 4'd0, 1'b0, "R6 read global");

        // R9: queue range
        run_cmd(4'd0, 1'b0, 16'(NQ), 64'h1234, 32'h40, 4'd0, 1'b0, "R9 sq queue out of range");
        run_cmd(4'd1, 1'b1, 16'hffff, 64'h5678, 32'h41, 4'd0, 1'b0, "R9 cq queue max");
        run_cmd(4'd0, 1'b0, 16'(NQ - 1), 64'h9999_0007, 32'h42, 4'd0, 1'b0, "R9 last queue accepted");
        run_cmd(4'd0, 1'b1, 16'(NQ - 1), 64'h0, 32'h43, 4'd0, 1'b0, "R9 last queue read");
        run_cmd(4'd8, 1'b0, 16'd9, 64'h77, 32'h44, 4'd0, 1'b0, "R9 close queue out of range");
        run_cmd(4'd10, 1'b1, 16'd7, 64'h78, 32'h45, 4'd0, 1'b0, "R9 flush queue in range");

        // R7: control commands
        run_cmd(4'd7,  1'b1, 16'd0, 64'h0707, 32'h50, 4'd0, 1'b0, "R7 close");
        run_cmd(4'd8,  1'b0, 16'd2, 64'h0808, 32'h51, 4'd0, 1'b0, "R7 close queue");
        run_cmd(4'd9,  1'b1, 16'd0, 64'h0909, 32'h52, 4'd0, 1'b0, "R7 flush");
        run_cmd(4'd12, 1'b0, 16'd0, 64'h0c0c, 32'h53, 4'd0, 1'b0, "R7 source");
        run_cmd(4'd13, 1'b1, 16'd0, 64'h0d0d, 32'h54, 4'd0, 1'b0, "R7 destination");
        run_cmd(4'd14, 1'b0, 16'd0, 64'h0e0e, 32'h55, 4'd0, 1'b0, "R7 stop");

        // R8: unknown codes
        run_cmd(4'd11, 1'b0, 16'd3, 64'hffff_ffff_ffff_ffff, 32'h60, 4'd0, 1'b0, "R8 code 11");
        run_cmd(4'd15, 1'b1, 16'd3, 64'h1357, 32'h61, 4'd0, 1'b0, "R8 code 15");
        run_cmd(4'd0, 1'b1, 16'd3, 64'h0, 32'h62, 4'd0, 1'b0, "R8 store untouched");

        // R10: software status replaced, ids kept
        run_cmd(4'd0, 1'b0, 16'd1, 64'h4242_4242_0001, 32'hfeed_f00d, 4'hf, 1'b0, "R10 status replaced");
        run_cmd(4'd11, 1'b1, 16'd1, 64'h0, 32'hbeef_0002, 4'h6, 1'b0, "R10 error status replaced");

        // R3: write during busy ignored
        run_cmd(4'd0, 1'b0, 16'd4, 64'h3333_0004_3333_0004, 32'h70, 4'd0, 1'b1, "R3 intruding write");
        run_cmd(4'd0, 1'b1, 16'd4, 64'h0, 32'h71, 4'd0, 1'b1, "R3 read after intrusion");

        while (mb_rd_data[13] || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule